// File: doc/BRIEF.md
# Flash command stream decoder

This block sits in front of a serial flash engine. A host hands it one flash command at a time as a stream of bytes. The first byte is the opcode. The decoder works out which header bytes the opcode needs, builds the address from them, and drops any timing filler byte. It then counts the write payload bytes that follow. When the byte flagged as final arrives, the decoder issues a single job descriptor. That descriptor carries the opcode, the address, the read and write direction flags, a fixed receive count for status and identification commands, a fixed transmit flag for the status write, and the payload length. The engine that shifts bits on the serial wires consumes these descriptors; that engine is not part of this block.

Bytes are taken on any cycle where `in_valid` is high, and there is no back-pressure. The host supplies the number of bytes it wants read back on `in_rd_len`, alongside the opcode byte only. A command may start on the cycle right after the previous command's final byte. Commands that cannot be carried out are still answered with one descriptor, which carries an error code in place of a job. There are three such cases: an unsupported opcode, a payload that both reads and writes, and a stream that stops before its header is complete.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `job_valid` is low and `job_err` is 0 until a command's final byte has been accepted.
- R2: Opcodes 0x06 (write enable), 0x04 (write disable) and 0xC7 (chip erase) need no header bytes. Their descriptor has address 0, no direction flag, `job_rx_fixed` 0 and `job_tx_fixed` 0.
- R3: `job_rx_fixed` is 3 for opcode 0x9F (JEDEC identification) and 1 for 0x05 (status read). It is also 1 for 0xAB (legacy identification), which first takes 3 filler address bytes.
- R4: Opcode 0x01 (status write) reports `job_tx_fixed` = 1, and the data byte it carries is counted as write payload.
- R5: Opcodes 0xD8 (sector erase), 0x03 (read), 0x0B (fast read), 0x02 (page program) and 0xAB each take 3 address bytes. The first of these bytes lands in `job_addr[23:16]` and the last in `job_addr[7:0]`. `job_rd` is set for 0x03 and 0x0B, and `job_wr` is set for 0x02.
- R6: For 0x0B, the one byte after the address is discarded: it reaches neither the address nor the payload count, and the descriptor reports opcode 0x03.
- R7: Any opcode outside the eleven listed ones yields `job_err` = 1 (invalid command).
- R8: `in_rd_len` is sampled only with the opcode byte. A command whose write payload is non-empty while that sample is non-zero yields `job_err` = 1.
- R9: A final byte that arrives before all header bytes (address and filler) have been received yields `job_err` = 2 (short command). For this case `job_addr` holds the address bytes that did arrive. Error value 3 never occurs.
- R10: `job_valid` is high for exactly the one cycle after each accepted final byte and low at all other times. Idle cycles with `in_valid` low are ignored.
- R11: On success, `job_len` is the count of write payload bytes if that count is non-zero, and the sampled `in_rd_len` otherwise. The count saturates at 2^LEN_W-1.
- R12: An error descriptor has `job_rd`, `job_wr`, `job_rx_fixed`, `job_tx_fixed` and `job_len` all at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A command byte is present this cycle |
| in_byte | input | 8 | Command byte |
| in_last | input | 1 | This byte ends the command |
| in_rd_len | input | LEN_W | Bytes to read back; sampled with the opcode byte |
| job_valid | output | 1 | Descriptor valid, one cycle |
| job_err | output | 2 | 0 ok, 1 invalid command, 2 short command |
| job_opcode | output | 8 | Opcode after fast-read rewrite |
| job_addr | output | 8*ADDR_BYTES | Assembled address, first byte most significant |
| job_rd | output | 1 | Read-direction job |
| job_wr | output | 1 | Write-direction job |
| job_rx_fixed | output | 2 | Fixed receive byte count |
| job_tx_fixed | output | 1 | One fixed data byte is sent |
| job_len | output | LEN_W | Payload byte count |

## Verification
Some properties are checked on every cycle. These cover the one-cycle pulse after each final byte, that an error descriptor never carries direction, counts or length, and that the two direction flags never appear together. They also check that a fast-read opcode never leaves the block and that error value 3 never appears. Other behaviour can only be shown by the bench's scenarios: the opcode table, the most-significant-first address order, where the filler byte goes, the priority of invalid over short over mixed, length saturation, and the fact that `in_rd_len` matters only on the opcode byte. These depend on whole byte sequences, so the bench compares each descriptor with a model built from the command bytes it sent.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_WRDI   = 8'h04;
  localparam logic [7:0] OP_CERASE = 8'hC7;
  localparam logic [7:0] OP_JID    = 8'h9F;
  localparam logic [7:0] OP_RSTAT  = 8'h05;
  localparam logic [7:0] OP_WSTAT  = 8'h01;
  localparam logic [7:0] OP_LID    = 8'hAB;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_FREAD  = 8'h0B;
  localparam logic [7:0] OP_PROG   = 8'h02;

  typedef enum logic [1:0] {
    FE_OK     = 2'd0,
    FE_BADCMD = 2'd1,
    FE_SHORT  = 2'd2
  } ferr_e;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_HDR = 2'd1,
    PH_PAY = 2'd2
  } phase_e;

  typedef struct packed {
    logic       known;
    logic       has_addr;
    logic       has_dummy;
    logic [1:0] rx_n;
    logic       tx_one;
    logic       rd;
    logic       wr;
  } opclass_t;

endpackage

// File: rtl/flash_op_classify.sv
module flash_op_classify
  import flash_dec_pkg::*;
(
  input  logic [7:0] op_i,
  output opclass_t   cls_o,
  output logic [7:0] op_o
);

  always_comb begin
    cls_o       = '0;
    cls_o.known = 1'b1;
    op_o        = op_i;
    case (op_i)
      OP_WREN, OP_WRDI, OP_CERASE: ;
      OP_JID:    cls_o.rx_n = 2'd3;
      OP_RSTAT:  cls_o.rx_n = 2'd1;
      OP_WSTAT:  cls_o.tx_one = 1'b1;
      OP_LID: begin
        cls_o.has_addr = 1'b1;
        cls_o.rx_n     = 2'd1;
      end
      OP_SERASE: cls_o.has_addr = 1'b1;
      OP_READ: begin
        cls_o.has_addr = 1'b1;
        cls_o.rd       = 1'b1;
      end
      OP_FREAD: begin
        cls_o.has_addr  = 1'b1;
        cls_o.has_dummy = 1'b1;
        cls_o.rd        = 1'b1;
        op_o            = OP_READ;
      end
      OP_PROG: begin
        cls_o.has_addr = 1'b1;
        cls_o.wr       = 1'b1;
      end
      default: cls_o.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/flash_hdr_track.sv
module flash_hdr_track
  import flash_dec_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int HDR_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat_i,
  input  logic                    last_i,
  input  logic [7:0]              byte_i,
  input  logic [HDR_W-1:0]        load_n_i,
  input  logic                    load_dummy_i,
  output phase_e                  phase_o,
  output logic                    short_o,
  output logic [8*ADDR_BYTES-1:0] addr_nx_o
);

  localparam int ADDR_W = 8 * ADDR_BYTES;

  phase_e             phase_q, phase_d;
  logic [HDR_W-1:0]   left_q, left_d;
  logic               dummy_q, dummy_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               opc_beat, hdr_beat, shift_en;

  assign opc_beat = beat_i && (phase_q == PH_OPC);
  assign hdr_beat = beat_i && (phase_q == PH_HDR);
  assign shift_en = hdr_beat && (left_q > HDR_W'(dummy_q));

  // address bytes enter at the low end and move up, so the first one ends on top
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_abyte
    logic [7:0] feed;
    if (g == 0) begin : g_low
      assign feed = byte_i;
    end else begin : g_up
      assign feed = addr_q[8*g-1 -: 8];
    end
    always_comb begin
      if (opc_beat)      addr_d[8*g +: 8] = 8'h00;
      else if (shift_en) addr_d[8*g +: 8] = feed;
      else               addr_d[8*g +: 8] = addr_q[8*g +: 8];
    end
  end

  always_comb begin
    phase_d = phase_q;
    left_d  = left_q;
    dummy_d = dummy_q;
    short_o = 1'b0;
    if (beat_i) begin
      case (phase_q)
        PH_OPC: begin
          dummy_d = load_dummy_i;
          left_d  = load_n_i;
          short_o = (load_n_i != '0);
          if (last_i)                phase_d = PH_OPC;
          else if (load_n_i == '0)   phase_d = PH_PAY;
          else                       phase_d = PH_HDR;
        end
        PH_HDR: begin
          left_d  = left_q - 1'b1;
          short_o = (left_q != HDR_W'(1));
          if (last_i)                    phase_d = PH_OPC;
          else if (left_q == HDR_W'(1))  phase_d = PH_PAY;
        end
        default: begin
          if (last_i) phase_d = PH_OPC;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPC;
      left_q  <= '0;
      dummy_q <= 1'b0;
      addr_q  <= '0;
    end else if (beat_i) begin
      phase_q <= phase_d;
      left_q  <= left_d;
      dummy_q <= dummy_d;
      addr_q  <= addr_d;
    end
  end

  assign phase_o   = phase_q;
  assign addr_nx_o = addr_d;

endmodule

// File: rtl/flash_pay_count.sv
module flash_pay_count #(
  parameter int LEN_W    = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [LEN_W-1:0] cnt_nx_o
);

  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q, step;

  if (SATURATE) begin : g_sat
    assign step = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  end else begin : g_wrap
    assign step = cnt_q + 1'b1;
  end

  always_comb begin
    if (clr_i)      cnt_nx_o = '0;
    else if (inc_i) cnt_nx_o = step;
    else            cnt_nx_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || inc_i) cnt_q <= cnt_nx_o;
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_dec_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [7:0]              in_byte,
  input  logic                    in_last,
  input  logic [LEN_W-1:0]        in_rd_len,
  output logic                    job_valid,
  output logic [1:0]              job_err,
  output logic [7:0]              job_opcode,
  output logic [8*ADDR_BYTES-1:0] job_addr,
  output logic                    job_rd,
  output logic                    job_wr,
  output logic [1:0]              job_rx_fixed,
  output logic                    job_tx_fixed,
  output logic [LEN_W-1:0]        job_len
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int HDR_W  = $clog2(ADDR_BYTES + 2);

  opclass_t          cls_now, cls_q, cls_eff;
  logic [7:0]        op_now, op_q, op_eff;
  logic [LEN_W-1:0]  rdlen_q, rdlen_eff;
  phase_e            phase;
  logic              beat_opc, fin, short_hit, mixed;
  logic [HDR_W-1:0]  hdr_load;
  logic [ADDR_W-1:0] addr_nx;
  logic [LEN_W-1:0]  wr_nx;
  ferr_e             err_d;

  flash_op_classify u_cls (
    .op_i  (in_byte),
    .cls_o (cls_now),
    .op_o  (op_now)
  );

  assign hdr_load = HDR_W'(cls_now.has_addr ? ADDR_BYTES : 0) + HDR_W'(cls_now.has_dummy);

  flash_hdr_track #(.ADDR_BYTES(ADDR_BYTES), .HDR_W(HDR_W)) u_hdr (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_i       (in_valid),
    .last_i       (in_last),
    .byte_i       (in_byte),
    .load_n_i     (hdr_load),
    .load_dummy_i (cls_now.has_dummy),
    .phase_o      (phase),
    .short_o      (short_hit),
    .addr_nx_o    (addr_nx)
  );

  assign beat_opc = in_valid && (phase == PH_OPC);

  flash_pay_count #(.LEN_W(LEN_W), .SATURATE(1'b1)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (beat_opc),
    .inc_i    (in_valid && (phase == PH_PAY)),
    .cnt_nx_o (wr_nx)
  );

  // per-command context, captured with the opcode byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q   <= '0;
      op_q    <= '0;
      rdlen_q <= '0;
    end else if (beat_opc) begin
      cls_q   <= cls_now;
      op_q    <= op_now;
      rdlen_q <= in_rd_len;
    end
  end

  assign cls_eff   = beat_opc ? cls_now   : cls_q;
  assign op_eff    = beat_opc ? op_now    : op_q;
  assign rdlen_eff = beat_opc ? in_rd_len : rdlen_q;

  assign fin   = in_valid && in_last;
  assign mixed = (wr_nx != '0) && (rdlen_eff != '0);

  always_comb begin
    if (!cls_eff.known) err_d = FE_BADCMD;
    else if (short_hit) err_d = FE_SHORT;
    else if (mixed)     err_d = FE_BADCMD;
    else                err_d = FE_OK;
  end

  logic                    vld_d;
  logic [1:0]              err_o_d;
  logic [7:0]              op_o_d;
  logic [ADDR_W-1:0]       addr_o_d;
  logic                    rd_o_d, wr_o_d, tx_o_d;
  logic [1:0]              rx_o_d;
  logic [LEN_W-1:0]        len_o_d;

  always_comb begin
    vld_d    = fin;
    err_o_d  = err_d;
    op_o_d   = op_eff;
    addr_o_d = addr_nx;
    rd_o_d   = 1'b0;
    wr_o_d   = 1'b0;
    rx_o_d   = 2'd0;
    tx_o_d   = 1'b0;
    len_o_d  = '0;
    if (err_d == FE_OK) begin
      rd_o_d  = cls_eff.rd;
      wr_o_d  = cls_eff.wr;
      rx_o_d  = cls_eff.rx_n;
      tx_o_d  = cls_eff.tx_one;
      len_o_d = (wr_nx != '0) ? wr_nx : rdlen_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) job_valid <= 1'b0;
    else        job_valid <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      job_err      <= 2'd0;
      job_opcode   <= '0;
      job_addr     <= '0;
      job_rd       <= 1'b0;
      job_wr       <= 1'b0;
      job_rx_fixed <= 2'd0;
      job_tx_fixed <= 1'b0;
      job_len      <= '0;
    end else if (fin) begin
      job_err      <= err_o_d;
      job_opcode   <= op_o_d;
      job_addr     <= addr_o_d;
      job_rd       <= rd_o_d;
      job_wr       <= wr_o_d;
      job_rx_fixed <= rx_o_d;
      job_tx_fixed <= tx_o_d;
      job_len      <= len_o_d;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int LEN_W      = 8,
  parameter int ADDR_BYTES = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_last,
  input logic                    job_valid,
  input logic [1:0]              job_err,
  input logic [7:0]              job_opcode,
  input logic                    job_rd,
  input logic                    job_wr,
  input logic [1:0]              job_rx_fixed,
  input logic                    job_tx_fixed,
  input logic [LEN_W-1:0]        job_len
);

  p_pulse_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> job_valid);

  p_pulse_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && $past(rst_n)) |-> $past(in_valid && in_last));

  p_err_clean_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_err != 2'd0) |->
      (!job_rd && !job_wr && job_rx_fixed == 2'd0 && !job_tx_fixed && job_len == '0));

  p_one_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> !(job_rd && job_wr));

  p_no_fastread_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> (job_opcode != 8'h0B));

  p_err_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid |-> (job_err != 2'd3));

  p_jid_rx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (job_valid && job_err == 2'd0 && job_opcode == 8'h9F) |-> (job_rx_fixed == 2'd3));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_last      (in_last),
  .job_valid    (job_valid),
  .job_err      (job_err),
  .job_opcode   (job_opcode),
  .job_rd       (job_rd),
  .job_wr       (job_wr),
  .job_rx_fixed (job_rx_fixed),
  .job_tx_fixed (job_tx_fixed),
  .job_len      (job_len)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_last;
  logic [7:0]  in_rd_len;
  logic        job_valid;
  logic [1:0]  job_err;
  logic [7:0]  job_opcode;
  logic [23:0] job_addr;
  logic        job_rd;
  logic        job_wr;
  logic [1:0]  job_rx_fixed;
  logic        job_tx_fixed;
  logic [7:0]  job_len;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_rd_len(in_rd_len), .job_valid(job_valid),
    .job_err(job_err), .job_opcode(job_opcode), .job_addr(job_addr),
    .job_rd(job_rd), .job_wr(job_wr), .job_rx_fixed(job_rx_fixed),
    .job_tx_fixed(job_tx_fixed), .job_len(job_len)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [1:0]  err;
    logic [7:0]  op;
    logic [23:0] addr;
    logic        rd;
    logic        wr;
    logic [1:0]  rx;
    logic        tx;
    logic [7:0]  len;
    string       tag;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] bt [0:319];
  int         nchk = 0;
  int         nerr = 0;
  logic       done = 1'b0;
  logic       mon_fin;

  function automatic exp_t model(int n, logic [7:0] rdl);
    exp_t e;
    logic known, ha, hd;
    int hdr, avail, wr;
    known = 1'b1; ha = 1'b0; hd = 1'b0;
    e.err = 2'd0; e.rd = 1'b0; e.wr = 1'b0; e.rx = 2'd0; e.tx = 1'b0;
    e.len = 8'd0; e.addr = 24'd0; e.tag = "R2";
    case (bt[0])
      8'h06, 8'h04, 8'hC7: ;
      8'h9F: begin e.rx = 2'd3; e.tag = "R3"; end
      8'h05: begin e.rx = 2'd1; e.tag = "R3"; end
      8'h01: begin e.tx = 1'b1; e.tag = "R4"; end
      8'hAB: begin ha = 1'b1; e.rx = 2'd1; e.tag = "R3"; end
      8'hD8: begin ha = 1'b1; e.tag = "R5"; end
      8'h03: begin ha = 1'b1; e.rd = 1'b1; e.tag = "R5"; end
      8'h0B: begin ha = 1'b1; hd = 1'b1; e.rd = 1'b1; e.tag = "R6"; end
      8'h02: begin ha = 1'b1; e.wr = 1'b1; e.tag = "R5"; end
      default: known = 1'b0;
    endcase
    e.op  = (bt[0] == 8'h0B) ? 8'h03 : bt[0];
    hdr   = (ha ? 3 : 0) + (hd ? 1 : 0);
    avail = n - 1;
    if (ha)
      for (int i = 1; i <= 3 && i <= avail; i++) e.addr = {e.addr[15:0], bt[i]};
    wr = avail - hdr;
    if (!known) begin
      e.err = 2'd1; e.tag = "R7";
    end else if (avail < hdr) begin
      e.err = 2'd2; e.tag = "R9";
    end else if (wr != 0 && rdl != 8'd0) begin
      e.err = 2'd1; e.tag = "R8";
    end
    if (e.err != 2'd0) begin
      e.rd = 1'b0; e.wr = 1'b0; e.rx = 2'd0; e.tx = 1'b0; e.len = 8'd0;
    end else begin
      e.len = (wr != 0) ? ((wr > 255) ? 8'd255 : 8'(wr)) : rdl;
      if (wr > 255) e.tag = "R11";
    end
    return e;
  endfunction

  // drives bt[0..n-1] as one command; leaves in_valid high after the last byte
  task automatic send(int n, logic [7:0] rdl, bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
        in_last  = 1'($urandom);
      end
      @(negedge clk);
      in_valid  = 1'b1;
      in_byte   = bt[i];
      in_last   = (i == n - 1);
      in_rd_len = (i == 0) ? rdl : 8'($urandom);
      if (i == n - 1) expq.push_back(model(n, rdl));
    end
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic hdr_cmd(logic [7:0] op, int n, logic [7:0] rdl);
    bt[0] = op;
    for (int i = 1; i < n; i++) bt[i] = 8'($urandom);
    send(n, rdl, 1'b0);
  endtask

  // monitor: pulse timing and descriptor contents
  always @(posedge clk) begin
    mon_fin = rst_n && in_valid && in_last;
    #1;
    if (rst_n && !done) begin
      if (job_valid !== mon_fin) begin
        nchk++; nerr++;
        $display("FAIL R10 job_valid actual=%b expected=%b", job_valid, mon_fin);
      end
      if (job_valid === 1'b1) begin
        nchk++;
        if (expq.size() == 0) begin
          nerr++;
          $display("FAIL R10 unexpected descriptor actual=1 expected=0");
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (job_err !== e.err || job_opcode !== e.op || job_addr !== e.addr ||
              job_rd !== e.rd || job_wr !== e.wr || job_rx_fixed !== e.rx ||
              job_tx_fixed !== e.tx || job_len !== e.len) begin
            nerr++;
            $display("FAIL %s actual err=%0d op=%h addr=%h rd=%b wr=%b rx=%0d tx=%b len=%0d expected err=%0d op=%h addr=%h rd=%b wr=%b rx=%0d tx=%b len=%0d",
              e.tag, job_err, job_opcode, job_addr, job_rd, job_wr, job_rx_fixed,
              job_tx_fixed, job_len, e.err, e.op, e.addr, e.rd, e.wr, e.rx, e.tx, e.len);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [0:10];
    ops = '{8'h06, 8'h04, 8'hC7, 8'h9F, 8'h05, 8'h01, 8'hAB, 8'hD8, 8'h03, 8'h0B, 8'h02};
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0; in_rd_len = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    repeat (2) @(negedge clk);
    nchk++;
    if (job_valid !== 1'b0 || job_err !== 2'd0) begin
      nerr++;
      $display("FAIL R1 actual valid=%b err=%0d expected valid=0 err=0", job_valid, job_err);
    end

    // R2, R3, R4, R5: each opcode with exactly its header
    hdr_cmd(8'h06, 1, 8'd0); hdr_cmd(8'h04, 1, 8'd0); hdr_cmd(8'hC7, 1, 8'd0);
    hdr_cmd(8'h9F, 1, 8'd3); hdr_cmd(8'h05, 1, 8'd1); hdr_cmd(8'h01, 2, 8'd0);
    hdr_cmd(8'hAB, 4, 8'd1); hdr_cmd(8'hD8, 4, 8'd0);
    idle(2);
    // R5: address order with known bytes, read of 16
    bt[0] = 8'h03; bt[1] = 8'h12; bt[2] = 8'h34; bt[3] = 8'h56;
    send(4, 8'd16, 1'b0);
    // R6: fast read, dummy 0xEE must vanish
    bt[0] = 8'h0B; bt[1] = 8'hA1; bt[2] = 8'hB2; bt[3] = 8'hC3; bt[4] = 8'hEE;
    send(5, 8'd8, 1'b0);
    // R5 program with 5 payload bytes
    hdr_cmd(8'h02, 9, 8'd0);
    idle(1);
    // R7: unknown opcode
    hdr_cmd(8'h55, 3, 8'd0);
    // R8: mixed payload
    hdr_cmd(8'h02, 6, 8'd4);
    // R9: short address, short fast-read dummy
    hdr_cmd(8'hD8, 3, 8'd0);
    hdr_cmd(8'h0B, 4, 8'd0);
    hdr_cmd(8'hAB, 1, 8'd0);
    idle(3);
    // R11: saturation with 300 write bytes
    hdr_cmd(8'h02, 304, 8'd0);
    idle(2);

    // constrained random, with idle gaps (R10)
    for (int k = 0; k < 400; k++) begin
      int sel, n;
      logic [7:0] rdl;
      sel = int'($urandom % 13);
      bt[0] = (sel < 11) ? ops[sel] : 8'($urandom);
      n = 1 + int'($urandom % 10);
      for (int i = 1; i < n; i++) bt[i] = 8'($urandom);
      rdl = ($urandom % 3 == 0) ? 8'($urandom) : 8'd0;
      send(n, rdl, 1'b1);
      if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
    end
    idle(4);
    nchk++;
    if (expq.size() != 0) begin
      nerr++;
      $display("FAIL R10 missing descriptors actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule